// File: doc/BRIEF.md
# Enabled Multi-Order 3-Bit Counter

This block is a small synchronous counter whose three state bits walk through one of three fixed code orders: plain ascending, plain descending, or a stride order that adds three modulo eight on every step (000, 011, 110, 001, 100, 111, 010, 101, then 000 again). A count-enable input gates every step. When enable is low the value stays where it is. A two-bit order select picks the walk, and it may change at any time. The next code always comes from the present value under the newly selected order, so the counter is never forced back to the start of a sequence.

A one-cycle wrap flag marks the moment the selected order completes a loop. Surrounding logic can use it as a divided tick or as an end-of-pattern marker. The state updates only on the rising clock edge. A synchronous active-low reset clears the state and the flag.

Top module: `mseq_counter`

## Requirements
- R1: While `rst_n` is 0 at a rising edge, `count` becomes 000 and `wrap` becomes 0 after that edge, whatever `en` and `order_sel` are.
- R2: With `rst_n` high and `en` 0 at a rising edge, `count` keeps its value and `wrap` is 0 after that edge.
- R3: With `en` 1 and `order_sel` = 00 (ascending), `count` becomes the present value plus one modulo eight, so 111 is followed by 000.
- R4: With `en` 1 and `order_sel` = 01 (descending), `count` becomes the present value minus one modulo eight, so 000 is followed by 111.
- R5: With `en` 1 and `order_sel` = 10 (stride), `count` becomes the present value plus three modulo eight, visiting 000, 011, 110, 001, 100, 111, 010, 101 in that order.
- R6: `order_sel` = 11 behaves exactly like 00 (ascending).
- R7: A change of `order_sel` takes effect at the next enabled edge and starts from the present `count`, with no return to the order's first code.
- R8: `wrap` is 1 for the single cycle after an enabled edge that moved `count` from the last code to the first code of the order selected at that edge. The last/first pairs are 111/000 for ascending, 000/111 for descending, and 101/000 for stride. `wrap` is 0 after every other edge.
- R9: `count` bit 2 is the most significant bit of the code, and bit 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Count enable; 0 holds the value |
| order_sel | input | 2 | Order select: 00 up, 01 down, 10 stride of three, 11 up |
| count | output | 3 | Current code, bit 2 most significant |
| wrap | output | 1 | One-cycle loop-completion flag |

## Verification
The hardest case to reach from the ports is a wrap under one order that lands on a code which is the loop end of a different order. For example, an ascending wrap into 000 followed at once by a switch to descending gives two wrap cycles in a row. A stride loop entered at an arbitrary code is a similar case. Directed sequences set these up by reaching the boundary code first and then flipping `order_sel` on the next cycle. Seeded random runs then change the order, the enable and the occasional reset on every cycle, so that mid-sequence switches occur at all eight codes.

// File: rtl/mseq_counter_pkg.sv
// Package: shared order encoding for the multi-order counter.
// Assumes: the select is two bits wide and code 11 is an alias of ascending.
package mseq_counter_pkg;

    typedef enum logic [1:0] {
        ORD_UP     = 2'b00,
        ORD_DOWN   = 2'b01,
        ORD_STRIDE = 2'b10,
        ORD_ALIAS  = 2'b11
    } order_e;

    // Number of distinct next-code generators
    localparam int NUM_ORDERS = 3;

    // Map a select value onto a generator index (R6: alias -> ascending)
    function automatic int unsigned order_index(input logic [1:0] sel);
        case (sel)
            ORD_DOWN:   return 1;
            ORD_STRIDE: return 2;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/mseq_order_step.sv
// Module: one fixed code order. Gives the successor of the current code and
// flags whether the current code is the last one of the loop.
// Assumes: KIND 0 = +1, KIND 1 = -1, KIND 2 = +STRIDE; all arithmetic wraps
// modulo 2**WIDTH; STRIDE is odd, so the stride order visits every code.
module mseq_order_step #(
    parameter int WIDTH  = 3,
    parameter int STRIDE = 3,
    parameter int KIND   = 0
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt,
    output logic             at_last
);
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);
    localparam logic [WIDTH-1:0] STEP_V   = WIDTH'(STRIDE);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO     = '0;
    localparam logic [WIDTH-1:0] STR_LAST = ZERO - STEP_V;

    generate
        if (KIND == 1) begin : g_down
            // Descending: subtract one, loop ends at zero
            always_comb begin
                nxt     = cur - ONE;
                at_last = (cur == ZERO);
            end
        end else if (KIND == 2) begin : g_stride
            // Stride: add STRIDE, loop ends one stride before zero
            always_comb begin
                nxt     = cur + STEP_V;
                at_last = (cur == STR_LAST);
            end
        end else begin : g_up
            // Ascending: add one, loop ends at all ones
            always_comb begin
                nxt     = cur + ONE;
                at_last = (cur == ALL_ONES);
            end
        end
    endgenerate

endmodule

// File: rtl/mseq_state_reg.sv
// Module: state and wrap-flag registers with enable and synchronous reset.
// Assumes: nxt and at_last come from the generator of the selected order.
module mseq_state_reg #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] nxt,
    input  logic             at_last,
    output logic [WIDTH-1:0] state_q,
    output logic             wrap_q
);
    // Update the code on enabled edges; reset has priority
    always_ff @(posedge clk) begin
        if (!rst_n)  state_q <= '0;
        else if (en) state_q <= nxt;
    end

    // Flag one cycle when an enabled edge leaves the loop's last code
    always_ff @(posedge clk) begin
        if (!rst_n) wrap_q <= 1'b0;
        else        wrap_q <= en && at_last;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (state_q == '0 && !wrap_q)); // R1
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(state_q) && !wrap_q)); // R2
    AST_WRAP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> $past(en)); // R8

endmodule

// File: rtl/mseq_counter.sv
// Module: top of the multi-order counter. Builds one successor generator per
// order, selects one by order_sel and registers the result.
// Assumes: order_sel may change on any cycle; the new order starts from the
// present count.
module mseq_counter #(
    parameter int WIDTH  = 3,
    parameter int STRIDE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       order_sel,
    output logic [WIDTH-1:0] count,
    output logic             wrap
);
    import mseq_counter_pkg::*;

    localparam logic [WIDTH-1:0] STEP_V = WIDTH'(STRIDE);
    localparam logic [WIDTH-1:0] ONE    = WIDTH'(1);

    logic [WIDTH-1:0] nxt_arr  [NUM_ORDERS];
    logic             last_arr [NUM_ORDERS];
    logic [WIDTH-1:0] nxt_sel;
    logic             last_sel;
    logic [WIDTH-1:0] state_q;
    logic             wrap_q;

    // One generator per order
    generate
        for (genvar g = 0; g < NUM_ORDERS; g++) begin : g_ord
            mseq_order_step #(.WIDTH(WIDTH), .STRIDE(STRIDE), .KIND(g)) u_ord (
                .cur     (state_q),
                .nxt     (nxt_arr[g]),
                .at_last (last_arr[g])
            );
        end
    endgenerate

    // Pick the successor and last-code flag of the selected order
    always_comb begin
        nxt_sel  = nxt_arr[order_index(order_sel)];
        last_sel = last_arr[order_index(order_sel)];
    end

    mseq_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .nxt     (nxt_sel),
        .at_last (last_sel),
        .state_q (state_q),
        .wrap_q  (wrap_q)
    );

    assign count = state_q;
    assign wrap  = wrap_q;

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && order_sel[1] == order_sel[0]) |=> count == $past(count) + ONE); // R3
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && order_sel == ORD_DOWN) |=> count == $past(count) - ONE); // R4
    AST_STRIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && order_sel == ORD_STRIDE) |=> count == $past(count) + STEP_V); // R5
    AST_WRAP_LANDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && $past(order_sel) != ORD_DOWN) |-> count == '0); // R8

endmodule

// File: tb/mseq_counter_tb.sv
module mseq_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [1:0] order_sel;
    logic [2:0] count;
    logic       wrap;

    int n_checks = 0;
    int n_fail   = 0;
    logic [2:0] m_cnt;
    logic       m_wrap;

    always #2 clk = ~clk;

    mseq_counter u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .order_sel(order_sel),
        .count(count), .wrap(wrap)
    );

    function automatic logic [2:0] ref_next(input logic [1:0] s, input logic [2:0] c);
        case (s)
            2'b01:   return c - 3'd1;
            2'b10:   return c + 3'd3;
            default: return c + 3'd1;
        endcase
    endfunction

    function automatic logic [2:0] ref_last(input logic [1:0] s);
        case (s)
            2'b01:   return 3'd0;
            2'b10:   return 3'd5;
            default: return 3'd7;
        endcase
    endfunction

    function automatic string tag_of(input logic r, input logic e, input logic [1:0] s);
        if (!r) return "R1";
        if (!e) return "R2";
        case (s)
            2'b01:   return "R4";
            2'b10:   return "R5";
            2'b11:   return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, model at posedge, sample 1 ns later
    task automatic cyc(input logic r, input logic e, input logic [1:0] s);
        @(negedge clk);
        rst_n = r; en = e; order_sel = s;
        @(posedge clk);
        if (!r) begin
            m_cnt = 3'd0; m_wrap = 1'b0;
        end else if (e) begin
            m_wrap = (m_cnt == ref_last(s));
            m_cnt  = ref_next(s, m_cnt);
        end else begin
            m_wrap = 1'b0;
        end
        #1;
        check(tag_of(r, e, s), int'(count), int'(m_cnt));
        check("R8", int'(wrap), int'(m_wrap));
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [2:0] seen [8];
        void'($urandom(32'd1357));
        m_cnt = 3'd0; m_wrap = 1'b0;
        rst_n = 1'b0; en = 1'b1; order_sel = 2'b00;
        // R1: reset with enable high still clears
        repeat (3) cyc(1'b0, 1'b1, 2'b00);
        // R3: full ascending loop incl. 111 -> 000 wrap
        for (int i = 0; i < 9; i++) cyc(1'b1, 1'b1, 2'b00);
        // R2: hold with every select value
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 2'(i));
        // R4: descending through 000 -> 111
        cyc(1'b0, 1'b0, 2'b00);
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 2'b01);
        // R5 and R9: stride order from 000, codes compared by numeric value
        cyc(1'b0, 1'b0, 2'b10);
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1, 1'b1, 2'b10);
            seen[i] = count;
        end
        check("R5", int'(seen[0]), 3); check("R5", int'(seen[1]), 6);
        check("R9", int'(seen[2]), 1); check("R5", int'(seen[6]), 5);
        check("R5", int'(seen[7]), 0);
        // R6: alias order counts up
        for (int i = 0; i < 9; i++) cyc(1'b1, 1'b1, 2'b11);
        // R7/R8: ascending wrap into 000 then descending wrap at once
        cyc(1'b0, 1'b0, 2'b00);
        for (int i = 0; i < 7; i++) cyc(1'b1, 1'b1, 2'b00);
        cyc(1'b1, 1'b1, 2'b00);
        check("R8", int'(wrap), 1);
        cyc(1'b1, 1'b1, 2'b01);
        check("R7", int'(count), 7);
        check("R8", int'(wrap), 1);
        // R7: switch mid-sequence to stride from 111
        cyc(1'b1, 1'b1, 2'b10);
        check("R7", int'(count), 2);
        // R1: reset beats enable mid-count
        cyc(1'b0, 1'b1, 2'b10);
        check("R1", int'(count), 0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic r, e;
            logic [1:0] s;
            r = ($urandom_range(0, 49) != 0);
            e = ($urandom_range(0, 3) != 0);
            s = 2'($urandom_range(0, 3));
            cyc(r, e, s);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule